// File: doc/BRIEF.md
# Recirculating Operand Lane FIFO

This block is a bank of parallel word queues, one per arithmetic lane, that feed operand streams to a matrix update engine. Each queue is a first-in first-out buffer sized for the operand column of the state being processed. All lanes are popped together by one shared strobe, so the words presented on the lane outputs always belong to the same index position. Pushes are per lane.

In recirculate mode every word that is popped is written back at the tail of its own lane in the same cycle. An operand stream can therefore be consumed once in a first pass and then replayed whole, in the same order, in a second pass, without being reloaded. A second instance of the same block can collect first-pass results in order for use as a later operand. Illegal accesses are ignored and latched in a sticky error flag. A synchronous clear empties every lane at once.

Top module: `operand_lane_fifo`

## Requirements
- R1: After reset every lane is empty, no lane is full and the error flag is low.
- R2: Each lane holds DEPTH = ceil((7*NUM_LM+19)/LANES) words (12 with defaults), and its full flag is high exactly when it holds DEPTH words.
- R3: A pop with recirculate high presents the head word and writes that same word back at the tail of its lane in the same cycle, so full and empty do not change and repeated passes replay the words in their original order.
- R4: While recirculate is high, the external push data and push strobes have no effect on the lane contents.
- R5: Without recirculate, a pop removes the head word in first-in first-out order; the head word is visible on the lane output before the pop; a push and a pop in the same cycle leave the occupancy unchanged.
- R6: A push to a full lane or a pop of an empty lane is ignored and sets the error flag, which stays high until clear or reset.
- R7: Clear empties all lanes, resets their read and write positions and lowers the error flag in one cycle.
- R8: One pop and one recirculate strobe serve all lanes; lane i uses bits [32*i+31:32*i] of the data buses and bit i of the per-lane vectors, and each lane pops only if it is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Synchronous flush of all lanes and the error flag |
| pushEn | input | LANES | Per-lane push strobe |
| pushData | input | LANES*32 | Per-lane push word |
| popEn | input | 1 | Shared pop strobe |
| recircEn | input | 1 | Write popped words back at the tail |
| popData | output | LANES*32 | Head word of each lane |
| full | output | LANES | Lane holds DEPTH words |
| empty | output | LANES | Lane holds no word |
| errFlag | output | 1 | Sticky illegal-access flag |

## Verification
On every cycle the assertions check that a recirculating pop leaves full and empty untouched, that occupancy never exceeds the depth, that the error flag stays set until cleared, and that clear leaves all lanes empty with the flag low. What they cannot see is data order: only the bench scenarios show that two complete replay passes return the words in their pushed order, that push data offered during recirculation is discarded, and that a rejected overflow word never appears when the lane is drained.

// File: rtl/olf_pkg.sv
package olf_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic wrEn;
    logic useRecirc;
  } laneStrobe_t;
endpackage

// File: rtl/olf_lane_ctrl.sv
module olf_lane_ctrl
  import olf_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 12,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic [LANES-1:0]           pushEn,
  input  logic                       popEn,
  input  logic                       recircEn,
  output laneStrobe_t [LANES-1:0]    strobe,
  output logic [LANES-1:0][PW-1:0]   wrPtr,
  output logic [LANES-1:0][PW-1:0]   rdPtr,
  output logic [LANES-1:0]           full,
  output logic [LANES-1:0]           empty,
  output logic                       errFlag
);

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [LANES-1:0] badAccess;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [CW-1:0] cnt;
    logic doPop, doPush, badPop, badPush;

    assign full[i]  = (cnt == CW'(DEPTH));
    assign empty[i] = (cnt == '0);

    always_comb begin
      doPop   = popEn && !empty[i];
      badPop  = popEn && empty[i];
      doPush  = recircEn ? doPop : (pushEn[i] && !full[i]);
      badPush = !recircEn && pushEn[i] && full[i];
      strobe[i].wrEn      = doPush;
      strobe[i].useRecirc = recircEn;
      badAccess[i]        = badPop || badPush;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt      <= '0;
        wrPtr[i] <= '0;
        rdPtr[i] <= '0;
      end else if (clear) begin
        cnt      <= '0;
        wrPtr[i] <= '0;
        rdPtr[i] <= '0;
      end else begin
        if (doPush) wrPtr[i] <= nextPtr(wrPtr[i]);
        if (doPop)  rdPtr[i] <= nextPtr(rdPtr[i]);
        if (doPush && !doPop)      cnt <= cnt + 1'b1;
        else if (doPop && !doPush) cnt <= cnt - 1'b1;
      end
    end

    // R2: occupancy never passes the lane depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          errFlag <= 1'b0;
    else if (clear)      errFlag <= 1'b0;
    else if (|badAccess) errFlag <= 1'b1;
  end

  // R3: a recirculating pop keeps every lane's flags where they were
  a_r3_recirc_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (recircEn && popEn && !clear) |=> ($stable(full) && $stable(empty)));

  // R6: the error flag only falls on clear
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (errFlag && !clear) |=> errFlag);

  // R7: clear leaves all lanes empty and the flag low
  a_r7_clear_flush: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> ((&empty) && !errFlag));

endmodule

// File: rtl/olf_lane_dp.sv
module olf_lane_dp
  import olf_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 12,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                          clk,
  input  laneStrobe_t [LANES-1:0]       strobe,
  input  logic [LANES-1:0][PW-1:0]      wrPtr,
  input  logic [LANES-1:0][PW-1:0]      rdPtr,
  input  logic [LANES*WORD_W-1:0]       pushData,
  output logic [LANES*WORD_W-1:0]       popData
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] headWord;
    logic [WORD_W-1:0] tailWord;

    assign headWord = mem[rdPtr[i]];
    assign tailWord = strobe[i].useRecirc ? headWord
                                          : pushData[i*WORD_W +: WORD_W];
    assign popData[i*WORD_W +: WORD_W] = headWord;

    always_ff @(posedge clk) begin
      if (strobe[i].wrEn) mem[wrPtr[i]] <= tailWord;
    end
  end

endmodule

// File: rtl/operand_lane_fifo.sv
module operand_lane_fifo
  import olf_pkg::*;
#(
  parameter int NUM_LM = 4,
  parameter int LANES  = 4,
  localparam int DEPTH = (7 * NUM_LM + 19 + LANES - 1) / LANES,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic [LANES-1:0]        pushEn,
  input  logic [LANES*32-1:0]     pushData,
  input  logic                    popEn,
  input  logic                    recircEn,
  output logic [LANES*32-1:0]     popData,
  output logic [LANES-1:0]        full,
  output logic [LANES-1:0]        empty,
  output logic                    errFlag
);

  laneStrobe_t [LANES-1:0]     strobe;
  logic [LANES-1:0][PW-1:0]    wrPtr;
  logic [LANES-1:0][PW-1:0]    rdPtr;

  olf_lane_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(clear), .pushEn(pushEn),
    .popEn(popEn), .recircEn(recircEn), .strobe(strobe),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .full(full), .empty(empty),
    .errFlag(errFlag)
  );

  olf_lane_dp #(.LANES(LANES), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .pushData(pushData), .popData(popData)
  );

endmodule

// File: tb/operand_lane_fifo_test.sv
module operand_lane_fifo_test;
  localparam int DEPTH = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear = 1'b0;
  logic [3:0]   pushEn = '0;
  logic [127:0] pushData = '0;
  logic         popEn = 1'b0;
  logic         recircEn = 1'b0;
  logic [127:0] popData;
  logic [3:0]   full, empty;
  logic         errFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  operand_lane_fifo uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .pushEn(pushEn),
    .pushData(pushData), .popEn(popEn), .recircEn(recircEn),
    .popData(popData), .full(full), .empty(empty), .errFlag(errFlag)
  );

  always #10 clk = ~clk;

  // row: push mask, pop, recirc, expected empty, expected full, expected error
  typedef struct packed {
    logic [3:0] push;
    logic       pop;
    logic       rc;
    logic [3:0] expEmpty;
    logic [3:0] expFull;
    logic       expErr;
  } row_t;

  localparam row_t VEC [5] = '{
    '{4'b0001, 1'b0, 1'b0, 4'b1110, 4'b0000, 1'b0},
    '{4'b1111, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0},
    '{4'b0000, 1'b1, 1'b0, 4'b1110, 4'b0000, 1'b0},
    '{4'b0000, 1'b1, 1'b1, 4'b1110, 4'b0000, 1'b1},
    '{4'b0000, 1'b1, 1'b0, 4'b1111, 4'b0000, 1'b1}
  };

  function automatic logic [127:0] pat(input int base, input int k);
    logic [127:0] v;
    for (int i = 0; i < 4; i++)
      v[i*32 +: 32] = 32'(base) | (32'(i) << 8) | 32'(k);
    return v;
  endfunction

  task automatic chk(input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] pu, input logic po, input logic rc,
                      input logic [127:0] d, input logic cl);
    @(negedge clk);
    pushEn = pu; popEn = po; recircEn = rc; pushData = d; clear = cl;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(4'b0000, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 empty", 128'(empty), 128'hF);
    chk("R1 full", 128'(full), 128'h0);
    chk("R1 err", 128'(errFlag), 128'h0);
    @(negedge clk); rst_n = 1'b1;

    // table walk: flags under mixed push/pop/recirc (R5, R6, R8)
    for (int r = 0; r < 5; r++) begin
      step(VEC[r].push, VEC[r].pop, VEC[r].rc, pat(32'h1000_0000, r), 1'b0);
      chk($sformatf("R8 row%0d empty", r), 128'(empty), 128'(VEC[r].expEmpty));
      chk($sformatf("R5 row%0d full", r), 128'(full), 128'(VEC[r].expFull));
      chk($sformatf("R6 row%0d err", r), 128'(errFlag), 128'(VEC[r].expErr));
    end

    // R7 clear flushes and lowers the error flag
    step(4'b1111, 1'b0, 1'b0, pat(32'h2000_0000, 0), 1'b0);
    step(4'b0000, 1'b0, 1'b0, '0, 1'b1);
    chk("R7 empty after clear", 128'(empty), 128'hF);
    chk("R7 err after clear", 128'(errFlag), 128'h0);
    idle();

    // R2 fill every lane to depth
    for (int k = 0; k < DEPTH; k++) begin
      step(4'b1111, 1'b0, 1'b0, pat(32'hA000_0000, k), 1'b0);
      if (k == DEPTH - 2) chk("R2 not full one short", 128'(full), 128'h0);
    end
    chk("R2 full at depth", 128'(full), 128'hF);
    chk("R2 err after fill", 128'(errFlag), 128'h0);
    // R6 overflow push is ignored and flagged
    step(4'b1111, 1'b0, 1'b0, pat(32'hDEAD_0000, 99), 1'b0);
    chk("R6 err on overflow", 128'(errFlag), 128'h1);
    chk("R6 full kept", 128'(full), 128'hF);

    // R3 two full replay passes in recirculate mode
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < DEPTH; k++) begin
        chk($sformatf("R3 pass%0d word%0d", pass, k), popData,
            pat(32'hA000_0000, k));
        step(4'b0000, 1'b1, 1'b1, '0, 1'b0);
        chk("R3 full held", 128'(full), 128'hF);
      end
    end

    // R5 plain drain in order; rejected overflow word never appears
    for (int k = 0; k < DEPTH; k++) begin
      chk($sformatf("R5 drain word%0d", k), popData, pat(32'hA000_0000, k));
      step(4'b0000, 1'b1, 1'b0, '0, 1'b0);
    end
    chk("R6 overflow word not stored", 128'(empty), 128'hF);
    chk("R6 err still set", 128'(errFlag), 128'h1);

    step(4'b0000, 1'b0, 1'b0, '0, 1'b1);
    // R5 push and pop together keep occupancy
    step(4'b1111, 1'b0, 1'b0, pat(32'hB000_0000, 1), 1'b0);
    step(4'b1111, 1'b1, 1'b0, pat(32'hB000_0000, 2), 1'b0);
    chk("R5 simultaneous empty", 128'(empty), 128'h0);
    chk("R5 simultaneous head", popData, pat(32'hB000_0000, 2));
    step(4'b0000, 1'b1, 1'b0, '0, 1'b0);
    chk("R5 one word left", 128'(empty), 128'hF);

    // R4 push data offered during recirculation is discarded
    step(4'b1111, 1'b0, 1'b0, pat(32'hC000_0000, 3), 1'b0);
    step(4'b1111, 1'b1, 1'b1, pat(32'hC000_0000, 4), 1'b0);
    chk("R4 head is recirculated word", popData, pat(32'hC000_0000, 3));
    step(4'b0000, 1'b1, 1'b0, '0, 1'b0);
    chk("R4 single word occupancy", 128'(empty), 128'hF);
    chk("R4 no error", 128'(errFlag), 128'h0);

    // R7 positions restart after clear
    step(4'b0011, 1'b0, 1'b0, pat(32'hE000_0000, 5), 1'b0);
    step(4'b0000, 1'b0, 1'b0, '0, 1'b1);
    step(4'b1111, 1'b0, 1'b0, pat(32'hE000_0000, 6), 1'b0);
    chk("R7 head after clear", popData, pat(32'hE000_0000, 6));

    idle();
    finish_run();
  end
endmodule